// File: doc/BRIEF.md
# Branch Condition and Target Unit

This combinational unit sits beside the execute stage of a 24-bit processor. From one instruction word and the operand values already read from the register file (A, D and B) plus the current program counter, it decides whether control leaves the sequential path and where it goes. It covers conditional relative branches that compare A with D, the compare-against-zero branches, and the absolute jumps with an immediate or register offset. Holding the program counter, fetching and flushing the pipeline belong to the surrounding core.

The instruction word is split as: bits [23:19] opcode (a branch when bits [23:22] are 11, with the three-bit condition in bits [21:19]), bits [18:15] the A register selector, bits [14:12] the D field, bits [11:0] the immediate. The decoder sorts each word into one of six kinds: KIND_NONE (not a branch), KIND_COND (condition 000 to 101, compare A with D), KIND_ZERO (condition 110/111 with D field 000, compare A with zero), KIND_JIMM (condition 110, D field 100), KIND_JREG (condition 111, D field 100) and KIND_BAD (condition 110/111 with any other D field). Being combinational, there are no states or transitions; the kind plays that role and selects the flag source, the decision and the target adder inputs.

Flags come from A + ~D + 1: Z when the 24-bit result is zero, N its top bit, C the carry out, V the signed overflow.

Top module: `bct_unit`

## Requirements
- R1: When instruction bits [23:22] are not 11, `taken_o` is 0 and `illegal_o` is 0.
- R2: Condition 000 (bits [21:19]) is taken when A equals D; condition 001 is taken when A differs from D.
- R3: Condition 010 is taken when A is below D as unsigned numbers; condition 011 when A is at or above D unsigned (carry out of A + ~D + 1 set).
- R4: Condition 100 is taken when A is below D as signed two's-complement numbers (N differs from V); condition 101 when A is at or above D signed, including operand pairs whose difference overflows.
- R5: For every word that is not a legal jump, `target_o` equals PC plus the sign-extended immediate bits [11:0], wrapping modulo 2^24.
- R6: Condition 110 with D field (bits [14:12]) 000 is taken when A is negative; condition 111 with D field 000 is taken when A is zero or positive; operand D is ignored.
- R7: Condition 110 with D field 100 is always taken, with target A plus the zero-extended immediate, modulo 2^24.
- R8: Condition 111 with D field 100 is always taken, with target A plus operand B, modulo 2^24.
- R9: Condition 110 or 111 with a D field other than 000 or 100 sets `illegal_o` and clears `taken_o`; no other word sets `illegal_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn_i | input | 24 | Instruction word |
| opa_i | input | 24 | Value of register A |
| opd_i | input | 24 | Value of register D |
| opb_i | input | 24 | Value of register B (register-offset jump) |
| pc_i | input | 24 | Address of the instruction |
| taken_o | output | 1 | Control transfer taken |
| target_o | output | 24 | Destination address |
| illegal_o | output | 1 | Unsupported branch-class encoding |

## Verification
A wrong decoded kind shows at once as a taken bit or target from the wrong family, such as a jump reporting PC-relative target or an illegal word reporting taken; since the unit has no storage, every fault is visible on the same cycle the word is presented. A wrong flag shows only for operand pairs on the edge of a comparison, so equal operands, sign-boundary values and overflowing differences are presented alongside a random sweep, and every cycle is compared with a behavioural model.

// File: rtl/bct_pkg.sv
package bct_pkg;

    localparam int DATA_W = 24;
    localparam int IMM_W  = 12;

    typedef enum logic [2:0] {
        KIND_NONE = 3'd0,
        KIND_COND = 3'd1,
        KIND_ZERO = 3'd2,
        KIND_JIMM = 3'd3,
        KIND_JREG = 3'd4,
        KIND_BAD  = 3'd5
    } bct_kind_e;

    typedef struct packed {
        logic zero;
        logic neg;
        logic carry;
        logic ovf;
    } bct_flags_t;

endpackage

// File: rtl/bct_flags.sv
module bct_flags
    import bct_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] lhs_i,
    input  logic [W-1:0] rhs_i,
    output bct_flags_t   flags_o
);
    logic [W:0]   sum;
    logic [W-1:0] res;

    always_comb begin
        sum = {1'b0, lhs_i} + {1'b0, ~rhs_i} + {{W{1'b0}}, 1'b1};
        res = sum[W-1:0];
        flags_o.zero  = (res == '0);
        flags_o.neg   = res[W-1];
        flags_o.carry = sum[W];
        flags_o.ovf   = (lhs_i[W-1] != rhs_i[W-1]) && (res[W-1] != lhs_i[W-1]);
    end
endmodule

// File: rtl/bct_decode.sv
module bct_decode
    import bct_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] insn_i,
    output bct_kind_e    kind_o,
    output logic [2:0]   cond_o
);
    localparam int COND_LO = W - 5;
    localparam int DF_LO   = W - 12;

    logic [1:0] cls;
    logic [2:0] dfield;

    always_comb begin
        cls    = insn_i[W-1:W-2];
        cond_o = insn_i[COND_LO+2:COND_LO];
        dfield = insn_i[DF_LO+2:DF_LO];
        kind_o = KIND_NONE;
        if (cls == 2'b11) begin
            unique case (cond_o)
                3'b110, 3'b111: begin
                    unique case (dfield)
                        3'b000:  kind_o = KIND_ZERO;
                        3'b100:  kind_o = cond_o[0] ? KIND_JREG : KIND_JIMM;
                        default: kind_o = KIND_BAD;
                    endcase
                end
                default: kind_o = KIND_COND;
            endcase
        end
    end
endmodule

// File: rtl/bct_resolve.sv
module bct_resolve
    import bct_pkg::*;
(
    input  bct_kind_e  kind_i,
    input  logic [2:0] cond_i,
    input  bct_flags_t flags_i,
    output logic       taken_o,
    output logic       illegal_o
);
    logic lt_signed;
    logic hit;

    always_comb begin
        lt_signed = flags_i.neg ^ flags_i.ovf;
        unique case (cond_i[2:1])
            2'b00:   hit = flags_i.zero;
            2'b01:   hit = !flags_i.carry;
            default: hit = lt_signed;
        endcase
        // odd condition codes are the inverted sense
        hit = hit ^ cond_i[0];
    end

    always_comb begin
        taken_o   = 1'b0;
        illegal_o = 1'b0;
        unique case (kind_i)
            KIND_NONE: taken_o = 1'b0;
            KIND_COND: taken_o = hit;
            KIND_ZERO: taken_o = hit;
            KIND_JIMM: taken_o = 1'b1;
            KIND_JREG: taken_o = 1'b1;
            KIND_BAD:  illegal_o = 1'b1;
            default:   taken_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/bct_target.sv
module bct_target
    import bct_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int IW = IMM_W
) (
    input  bct_kind_e     kind_i,
    input  logic [W-1:0]  pc_i,
    input  logic [W-1:0]  opa_i,
    input  logic [W-1:0]  opb_i,
    input  logic [IW-1:0] imm_i,
    output logic [W-1:0]  target_o
);
    logic [W-1:0] imm_sx;
    logic [W-1:0] imm_zx;
    logic [W-1:0] base;
    logic [W-1:0] offs;

    generate
        if (IW < W) begin : g_ext
            assign imm_sx = {{(W-IW){imm_i[IW-1]}}, imm_i};
            assign imm_zx = {{(W-IW){1'b0}}, imm_i};
        end else begin : g_trunc
            assign imm_sx = imm_i[W-1:0];
            assign imm_zx = imm_i[W-1:0];
        end
    endgenerate

    always_comb begin
        unique case (kind_i)
            KIND_JIMM: begin base = opa_i; offs = imm_zx; end
            KIND_JREG: begin base = opa_i; offs = opb_i;  end
            default:   begin base = pc_i;  offs = imm_sx; end
        endcase
        target_o = base + offs;
    end
endmodule

// File: rtl/bct_unit.sv
module bct_unit
    import bct_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int IW = IMM_W
) (
    input  logic [W-1:0] insn_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opd_i,
    input  logic [W-1:0] opb_i,
    input  logic [W-1:0] pc_i,
    output logic         taken_o,
    output logic [W-1:0] target_o,
    output logic         illegal_o
);
    bct_kind_e    kind;
    logic [2:0]   cond;
    logic [W-1:0] rhs;
    bct_flags_t   flags;

    bct_decode #(.W(W)) u_decode (
        .insn_i (insn_i),
        .kind_o (kind),
        .cond_o (cond)
    );

    // compare-with-zero forms substitute zero for operand D
    assign rhs = (kind == KIND_ZERO) ? '0 : opd_i;

    bct_flags #(.W(W)) u_flags (
        .lhs_i   (opa_i),
        .rhs_i   (rhs),
        .flags_o (flags)
    );

    bct_resolve u_resolve (
        .kind_i    (kind),
        .cond_i    (cond),
        .flags_i   (flags),
        .taken_o   (taken_o),
        .illegal_o (illegal_o)
    );

    bct_target #(.W(W), .IW(IW)) u_target (
        .kind_i   (kind),
        .pc_i     (pc_i),
        .opa_i    (opa_i),
        .opb_i    (opb_i),
        .imm_i    (insn_i[IW-1:0]),
        .target_o (target_o)
    );
endmodule

// File: rtl/bct_unit_chk.sv
module bct_unit_chk #(
    parameter int W  = 24,
    parameter int IW = 12
) (
    input logic [W-1:0] insn_i,
    input logic [W-1:0] opa_i,
    input logic [W-1:0] opb_i,
    input logic [W-1:0] pc_i,
    input logic         taken_o,
    input logic [W-1:0] target_o,
    input logic         illegal_o
);
    logic         br;
    logic [2:0]   cc;
    logic [2:0]   df;
    logic         jmp;
    logic [W-1:0] rel;

    always_comb begin
        br  = (insn_i[W-1:W-2] == 2'b11);
        cc  = insn_i[W-3:W-5];
        df  = insn_i[W-10:W-12];
        jmp = br && cc[2] && cc[1] && (df == 3'b100);
        rel = pc_i + {{(W-IW){insn_i[IW-1]}}, insn_i[IW-1:0]};
    end

    always_comb begin
        if (!br) begin
            AST_NONBRANCH_QUIET: assert (!taken_o && !illegal_o); // R1
        end
        if (!jmp) begin
            AST_REL_TARGET: assert (target_o == rel); // R5
        end
        if (jmp && !cc[0]) begin
            AST_JIMM_TARGET: assert (taken_o && target_o == opa_i + {{(W-IW){1'b0}}, insn_i[IW-1:0]}); // R7
        end
        if (jmp && cc[0]) begin
            AST_JREG_TARGET: assert (taken_o && target_o == opa_i + opb_i); // R8
        end
        if (illegal_o) begin
            AST_ILLEGAL_IDLE: assert (!taken_o && br && cc[2] && cc[1]); // R9
        end
        if (br && cc == 3'b000 && taken_o) begin
            AST_EQ_ZERO_DIFF: assert (!illegal_o); // R2
        end
    end
endmodule

bind bct_unit bct_unit_chk #(.W(W), .IW(IW)) u_chk (
    .insn_i    (insn_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .pc_i      (pc_i),
    .taken_o   (taken_o),
    .target_o  (target_o),
    .illegal_o (illegal_o)
);

// File: tb/bct_unit_bench.sv
module bct_unit_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic [23:0] insn, opa, opd, opb, pc;
    logic        taken, illegal;
    logic [23:0] target;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    bct_unit u_bct_unit (
        .insn_i    (insn),
        .opa_i     (opa),
        .opd_i     (opd),
        .opb_i     (opb),
        .pc_i      (pc),
        .taken_o   (taken),
        .target_o  (target),
        .illegal_o (illegal)
    );

    function automatic string req_of(input logic [23:0] w);
        int c = int'(w[21:19]);
        int d = int'(w[14:12]);
        if (w[23:22] != 2'b11) return "R1";
        if (c <= 1) return "R2";
        if (c <= 3) return "R3";
        if (c <= 5) return "R4";
        if (d == 0) return "R6";
        if (d == 4) return (c == 6) ? "R7" : "R8";
        return "R9";
    endfunction

    task automatic model(input logic [23:0] w, a, d, b, p,
                         output bit tk, output logic [23:0] tg, output bit il);
        int c = int'(w[21:19]);
        int f = int'(w[14:12]);
        longint ua = longint'(a);
        longint ud = longint'(d);
        int sa = int'($signed(a));
        int sd = int'($signed(d));
        int simm = int'($signed(w[11:0]));
        tk = 0; il = 0;
        tg = 24'(longint'(p) + longint'(simm));
        if (w[23:22] == 2'b11) begin
            case (c)
                0: tk = (ua == ud);
                1: tk = (ua != ud);
                2: tk = (ua < ud);
                3: tk = (ua >= ud);
                4: tk = (sa < sd);
                5: tk = (sa >= sd);
                default: begin
                    if (f == 0) tk = (c == 6) ? (sa < 0) : (sa >= 0);
                    else if (f == 4) begin
                        tk = 1;
                        tg = (c == 6) ? 24'(ua + longint'(w[11:0])) : 24'(ua + longint'(b));
                    end else il = 1;
                end
            endcase
        end
    endtask

    task automatic apply(input logic [23:0] w, a, d, b, p, input string note);
        bit ek, ei;
        logic [23:0] et;
        @(posedge clk);
        insn = w; opa = a; opd = d; opb = b; pc = p;
        @(negedge clk);
        model(w, a, d, b, p, ek, et, ei);
        checks++;
        if (taken !== ek || target !== et || illegal !== ei) begin
            errors++;
            $display("FAIL %s %s insn=%h: actual taken=%0b target=%h illegal=%0b expected taken=%0b target=%h illegal=%0b",
                     req_of(w), note, w, taken, target, illegal, ek, et, ei);
        end
    endtask

    function automatic logic [23:0] mk(input logic [2:0] c, input logic [2:0] f, input logic [11:0] i);
        return {2'b11, c, 4'h3, f, i};
    endfunction

    initial begin
        insn = '0; opa = '0; opd = '0; opb = '0; pc = '0;
        @(negedge clk);
        checks++;
        if (taken !== 1'b0 || illegal !== 1'b0 || target !== 24'h0) begin
            errors++;
            $display("FAIL R1 idle: actual taken=%0b illegal=%0b target=%h expected 0 0 000000", taken, illegal, target);
        end
        // R1 non-branch words
        apply(24'h012345, 24'h5, 24'h5, 24'h0, 24'h100, "alu word");
        apply(24'hA3F000, 24'h0, 24'h0, 24'h0, 24'h200, "load word");
        // R2 equality
        apply(mk(3'b000, 3'b010, 12'h010), 24'h123456, 24'h123456, 0, 24'h400, "beq equal");
        apply(mk(3'b000, 3'b010, 12'h010), 24'h123456, 24'h123457, 0, 24'h400, "beq differ");
        apply(mk(3'b001, 3'b010, 12'hFF0), 24'h000001, 24'h000002, 0, 24'h400, "bne differ");
        apply(mk(3'b001, 3'b010, 12'hFF0), 24'hFFFFFF, 24'hFFFFFF, 0, 24'h400, "bne equal");
        // R3 unsigned
        apply(mk(3'b010, 3'b001, 12'h004), 24'h000001, 24'hFFFFFF, 0, 24'h10, "bltu small");
        apply(mk(3'b010, 3'b001, 12'h004), 24'hFFFFFF, 24'h000001, 0, 24'h10, "bltu large");
        apply(mk(3'b011, 3'b001, 12'h004), 24'h000007, 24'h000007, 0, 24'h10, "bgeu equal");
        apply(mk(3'b011, 3'b001, 12'h004), 24'h000000, 24'h000001, 0, 24'h10, "bgeu below");
        // R4 signed with overflow
        apply(mk(3'b100, 3'b011, 12'h020), 24'h800000, 24'h000001, 0, 24'h30, "blt overflow");
        apply(mk(3'b100, 3'b011, 12'h020), 24'h7FFFFF, 24'hFFFFFF, 0, 24'h30, "blt pos vs neg");
        apply(mk(3'b101, 3'b011, 12'h020), 24'h7FFFFF, 24'h800000, 0, 24'h30, "bge overflow");
        apply(mk(3'b101, 3'b011, 12'h020), 24'hFFFFFE, 24'hFFFFFF, 0, 24'h30, "bge neg");
        // R5 wrap of relative target
        apply(mk(3'b000, 3'b000, 12'h800), 24'h0, 24'h0, 0, 24'h000100, "wrap low");
        apply(mk(3'b000, 3'b001, 12'h7FF), 24'h0, 24'h0, 0, 24'hFFFF80, "wrap high");
        // R6 compare with zero, D ignored
        apply(mk(3'b110, 3'b000, 12'h040), 24'h800000, 24'h800000, 0, 24'h50, "bltz neg");
        apply(mk(3'b110, 3'b000, 12'h040), 24'h000000, 24'hFFFFFF, 0, 24'h50, "bltz zero");
        apply(mk(3'b111, 3'b000, 12'h040), 24'h000000, 24'h000005, 0, 24'h50, "bgez zero");
        apply(mk(3'b111, 3'b000, 12'h040), 24'hFFFFFF, 24'h000000, 0, 24'h50, "bgez neg");
        // R7 immediate jump, zero-extended
        apply(mk(3'b110, 3'b100, 12'hFFF), 24'h001000, 24'h0, 24'h0, 24'h60, "jump imm");
        apply(mk(3'b110, 3'b100, 12'h010), 24'hFFFFF8, 24'h0, 24'h0, 24'h60, "jump imm wrap");
        // R8 register jump
        apply(mk(3'b111, 3'b100, 12'h123), 24'h000100, 24'h0, 24'h000020, 24'h60, "jump reg");
        apply(mk(3'b111, 3'b100, 12'h000), 24'hFFFFFF, 24'h0, 24'h000002, 24'h60, "jump reg wrap");
        // R9 illegal D fields
        for (int f = 0; f < 8; f++) begin
            if (f != 0 && f != 4) begin
                apply(mk(3'b110, 3'(f), 12'h001), 24'h800000, 24'h0, 24'h1, 24'h70, "illegal 110");
                apply(mk(3'b111, 3'(f), 12'h001), 24'h000001, 24'h0, 24'h1, 24'h70, "illegal 111");
            end
        end
        // random sweep across all kinds
        for (int n = 0; n < 3000; n++) begin
            logic [23:0] w = 24'($urandom);
            logic [23:0] a = 24'($urandom);
            logic [23:0] d = (n % 4 == 0) ? a : 24'($urandom);
            if (n % 2 == 0) w[23:22] = 2'b11;
            apply(w, a, d, 24'($urandom), 24'($urandom), "sweep");
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule